// File: doc/BRIEF.md
# Out-of-Order Issue Window State Tracker

This block keeps a small, fixed set of in-flight operations (eight slots by default) and tracks which progress class each one is in: waiting, pending, ready or issued. Each slot stores the operation's tag, an age stamp taken from a dispatch counter, a count of known consumers, a mask of the execution resources it needs, two source-operand tags with ready and latency-known flags, a memory-dependency flag and an urgent flag. Register renaming, the execution units and memory ordering live outside the block. They reach it through broadcast inputs: an operand becomes available, a producer's latency becomes known, a memory dependency clears, or a write-back completes.

One operation may be presented for dispatch per cycle. The block answers at once with a status code and accepts the operation only when the code is "ok". On each clock edge the block promotes slots between classes and picks one ready slot whose resources are all free. The pick favours urgent slots, then the lowest rank (age minus consumer count), then the older slot. The block also reports, one cycle late, which resources held back a ready slot. Slots can change class in the same cycle that a broadcast arrives, so the surrounding pipeline sees wakeups with no extra cycle of delay.

Top module: `iqt_window`

## Requirements
- R1: After synchronous reset every class vector, the promotion event vectors, `issue_valid`, `busy_res` and `token_stall` are zero.
- R2: An accepted dispatch goes into the lowest-numbered free slot (bit i of every class vector is slot i). It enters ready if both operands are available and no memory dependency is open. Otherwise it enters pending if both operand latencies are known, where an available operand counts as known. Otherwise it enters waiting. Broadcasts presented in the same cycle count toward this choice.
- R3: A wakeup broadcast marks every source operand that names its tag as available in the same clock edge. A latency broadcast marks matching operands as latency-known. A memory-clear broadcast clears the memory dependency of the slot holding that tag.
- R4: A waiting slot whose two latencies become known moves to pending and raises its `to_pend_vec` bit for one cycle. A pending slot whose operands are all available and whose memory dependency is clear moves to ready and raises its `to_rdy_vec` bit. A waiting slot that meets both conditions at once goes straight to ready and raises both bits.
- R5: `disp_status` gives 3 (window full) when all slots are occupied. Otherwise it gives 1 for a load while the load queue is full, then 2 for a store while the store queue is full, then 4 while the group-hold input is high, and 0 otherwise. A refused dispatch leaves all slot state unchanged.
- R6: `token_stall` is high in the cycle after a dispatch that was refused with code 1, 2 or 3. It is low after an accepted dispatch, after a refusal with code 4, and after a cycle with no request.
- R7: At most one slot issues per edge, and only a ready slot whose resource mask lies within `res_free` can issue. Among candidates the lowest rank wins, where rank is age minus consumer count. A tie goes to the smaller age. The issued tag appears on `issue_tag` with `issue_valid` high one edge after the choice, and the slot moves to issued on that same edge.
- R8: An urgent ready candidate beats every non-urgent candidate, whatever the ranks.
- R9: `busy_res` holds, for the previous cycle only, the OR of the required-but-not-free resource bits of all slots that were ready in that cycle. It is rebuilt from zero on every edge.
- R10: A write-back tag frees the slot holding that tag only if the slot is in the issued class. The freed slot can take a new dispatch on the next cycle.
- R11: Dispatching a tag that a valid slot still holds is a protocol error and is flagged as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | TAG_W | Tag of the dispatched operation |
| disp_src0 | input | TAG_W | Producer tag of source 0 |
| disp_src1 | input | TAG_W | Producer tag of source 1 |
| disp_src_rdy | input | 2 | Source available at dispatch (bit per source) |
| disp_lat_known | input | 2 | Source producer latency known at dispatch |
| disp_mem_dep | input | 1 | Operation has an open memory dependency |
| disp_res | input | NRES | Resources the operation needs |
| disp_users | input | USR_W | Number of known consumers |
| disp_urgent | input | 1 | Zero-latency or must-issue-at-once operation |
| disp_is_load | input | 1 | Operation needs a load-queue entry |
| disp_is_store | input | 1 | Operation needs a store-queue entry |
| lq_full | input | 1 | Load queue has no room |
| sq_full | input | 1 | Store queue has no room |
| grp_hold | input | 1 | Dispatch group must stall |
| disp_status | output | 3 | Dispatch answer code (R5) |
| token_stall | output | 1 | Previous dispatch lacked window or queue space |
| wake_valid | input | 1 | Operand-available broadcast |
| wake_tag | input | TAG_W | Producer tag now available |
| lat_valid | input | 1 | Latency-known broadcast |
| lat_tag | input | TAG_W | Producer tag whose latency is now known |
| mem_clr_valid | input | 1 | Memory-dependency-clear broadcast |
| mem_clr_tag | input | TAG_W | Tag of the operation whose dependency cleared |
| res_free | input | NRES | Resources free this cycle |
| wb_valid | input | 1 | Write-back completion |
| wb_tag | input | TAG_W | Tag that completed |
| issue_valid | output | 1 | An operation issued on the last edge |
| issue_tag | output | TAG_W | Tag of that operation |
| busy_res | output | NRES | Resources that held back a ready slot last cycle |
| wait_vec | output | DEPTH | Slots in the waiting class |
| pend_vec | output | DEPTH | Slots in the pending class |
| rdy_vec | output | DEPTH | Slots in the ready class |
| iss_vec | output | DEPTH | Slots in the issued class |
| to_pend_vec | output | DEPTH | Slots promoted into pending on the last edge |
| to_rdy_vec | output | DEPTH | Slots promoted into ready on the last edge |

## Verification
Slot state is visible at the ports through the four class vectors, so a wrong class or a lost wakeup shows one edge after the broadcast that should have moved the slot. A corrupted age, consumer count or resource mask shows later, as a wrong `issue_tag` order or a wrong `busy_res` bit once resources are granted or withheld. A stuck valid bit shows as a slot that never returns to the free pool after its write-back, which then changes where the next dispatch lands and when `disp_status` reports a full window.

// File: rtl/iqt_pkg.sv
package iqt_pkg;

  typedef enum logic [1:0] {
    CL_WAIT = 2'd0,
    CL_PEND = 2'd1,
    CL_RDY  = 2'd2,
    CL_ISS  = 2'd3
  } cls_e;

  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_LQ_FULL   = 3'd1,
    ST_SQ_FULL   = 3'd2,
    ST_WIN_FULL  = 3'd3,
    ST_GRP_STALL = 3'd4
  } disp_st_e;

  // Class of an operation given merged operand flags (known already includes ready).
  function automatic cls_e entry_class(input logic [1:0] rdy, input logic [1:0] known,
                                       input logic mem);
    if (&rdy && !mem) return CL_RDY;
    else if (&known) return CL_PEND;
    else return CL_WAIT;
  endfunction

endpackage

// File: rtl/iqt_slot.sv
module iqt_slot import iqt_pkg::*; #(
  parameter int TAG_W = 4,
  parameter int NRES  = 4,
  parameter int USR_W = 3,
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TAG_W-1:0] wr_src0,
  input  logic [TAG_W-1:0] wr_src1,
  input  logic [1:0]       wr_rdy,
  input  logic [1:0]       wr_known,
  input  logic             wr_mem,
  input  cls_e             wr_cls,
  input  logic [NRES-1:0]  wr_res,
  input  logic [USR_W-1:0] wr_users,
  input  logic             wr_urgent,
  input  logic [AGE_W-1:0] wr_age,
  input  logic             wake_valid,
  input  logic [TAG_W-1:0] wake_tag,
  input  logic             lat_valid,
  input  logic [TAG_W-1:0] lat_tag,
  input  logic             mem_clr_valid,
  input  logic [TAG_W-1:0] mem_clr_tag,
  input  logic             issue_go,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             o_valid,
  output cls_e             o_cls,
  output logic [TAG_W-1:0] o_tag,
  output logic [AGE_W-1:0] o_age,
  output logic [USR_W-1:0] o_users,
  output logic [NRES-1:0]  o_res,
  output logic             o_urgent,
  output logic             o_to_pend,
  output logic             o_to_rdy
);
  logic [TAG_W-1:0] src0_q, src1_q;
  logic [1:0]       rdy_q, known_q, rdy_n, known_n;
  logic             mem_q, mem_n, all_rdy, all_known;

  assign rdy_n   = rdy_q | {wake_valid && wake_tag == src1_q, wake_valid && wake_tag == src0_q};
  assign known_n = known_q | rdy_n |
                   {lat_valid && lat_tag == src1_q, lat_valid && lat_tag == src0_q};
  assign mem_n   = mem_q && !(mem_clr_valid && mem_clr_tag == o_tag);
  assign all_rdy   = (&rdy_n) && !mem_n;
  assign all_known = &known_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0; o_cls <= CL_WAIT; o_tag <= '0; o_age <= '0; o_users <= '0;
      o_res <= '0; o_urgent <= 1'b0; o_to_pend <= 1'b0; o_to_rdy <= 1'b0;
      src0_q <= '0; src1_q <= '0; rdy_q <= '0; known_q <= '0; mem_q <= 1'b0;
    end else begin
      o_to_pend <= 1'b0;
      o_to_rdy  <= 1'b0;
      if (wr_en) begin
        o_valid <= 1'b1; o_cls <= wr_cls; o_tag <= wr_tag; o_age <= wr_age;
        o_users <= wr_users; o_res <= wr_res; o_urgent <= wr_urgent;
        src0_q <= wr_src0; src1_q <= wr_src1; rdy_q <= wr_rdy; known_q <= wr_known;
        mem_q <= wr_mem;
      end else if (o_valid) begin
        rdy_q   <= rdy_n;
        known_q <= known_n;
        mem_q   <= mem_n;
        unique case (o_cls)
          CL_WAIT: if (all_known) begin
            o_to_pend <= 1'b1;
            if (all_rdy) begin o_cls <= CL_RDY; o_to_rdy <= 1'b1; end
            else o_cls <= CL_PEND;
          end
          CL_PEND: if (all_rdy) begin o_cls <= CL_RDY; o_to_rdy <= 1'b1; end
          CL_RDY:  if (issue_go) o_cls <= CL_ISS;
          CL_ISS:  if (wb_valid && wb_tag == o_tag) o_valid <= 1'b0;
          default: o_cls <= CL_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/iqt_select.sv
module iqt_select #(
  parameter int DEPTH  = 8,
  parameter int AGE_W  = 8,
  parameter int RANK_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic [DEPTH-1:0]         cand,
  input  logic [DEPTH-1:0]         urgent,
  input  logic signed [RANK_W-1:0] rank [DEPTH],
  input  logic [AGE_W-1:0]         age  [DEPTH],
  output logic                     found,
  output logic [IDX_W-1:0]         pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i]) begin
        if (!found) begin
          found = 1'b1;
          pick  = IDX_W'(i);
        end else if (urgent[i] && !urgent[pick]) begin
          pick = IDX_W'(i);
        end else if (urgent[i] == urgent[pick] &&
                     (rank[i] < rank[pick] ||
                      (rank[i] == rank[pick] && age[i] < age[pick]))) begin
          pick = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/iqt_window.sv
module iqt_window import iqt_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4,
  parameter int NRES  = 4,
  parameter int USR_W = 3,
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_valid,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic [TAG_W-1:0] disp_src0,
  input  logic [TAG_W-1:0] disp_src1,
  input  logic [1:0]       disp_src_rdy,
  input  logic [1:0]       disp_lat_known,
  input  logic             disp_mem_dep,
  input  logic [NRES-1:0]  disp_res,
  input  logic [USR_W-1:0] disp_users,
  input  logic             disp_urgent,
  input  logic             disp_is_load,
  input  logic             disp_is_store,
  input  logic             lq_full,
  input  logic             sq_full,
  input  logic             grp_hold,
  output logic [2:0]       disp_status,
  output logic             token_stall,
  input  logic             wake_valid,
  input  logic [TAG_W-1:0] wake_tag,
  input  logic             lat_valid,
  input  logic [TAG_W-1:0] lat_tag,
  input  logic             mem_clr_valid,
  input  logic [TAG_W-1:0] mem_clr_tag,
  input  logic [NRES-1:0]  res_free,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             issue_valid,
  output logic [TAG_W-1:0] issue_tag,
  output logic [NRES-1:0]  busy_res,
  output logic [DEPTH-1:0] wait_vec,
  output logic [DEPTH-1:0] pend_vec,
  output logic [DEPTH-1:0] rdy_vec,
  output logic [DEPTH-1:0] iss_vec,
  output logic [DEPTH-1:0] to_pend_vec,
  output logic [DEPTH-1:0] to_rdy_vec
);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RANK_W = AGE_W + 2;

  logic [DEPTH-1:0]         occ, urg_v, go, cand, wr_sel;
  cls_e                     cls_v    [DEPTH];
  logic [TAG_W-1:0]         slot_tag [DEPTH];
  logic [AGE_W-1:0]         slot_age [DEPTH];
  logic [USR_W-1:0]         slot_usr [DEPTH];
  logic [NRES-1:0]          slot_res [DEPTH];
  logic signed [RANK_W-1:0] rank     [DEPTH];
  logic [AGE_W-1:0]         age_ctr;
  disp_st_e                 st;
  logic                     accept, sel_v;
  logic [IDX_W-1:0]         sel_idx;
  logic [1:0]               in_rdy, in_known;
  logic                     in_mem;
  cls_e                     in_cls;
  logic [NRES-1:0]          busy_n;

  // Dispatch answer: window space first, then the queues, then the group hold.
  always_comb begin
    if (&occ)                            st = ST_WIN_FULL;
    else if (disp_is_load && lq_full)    st = ST_LQ_FULL;
    else if (disp_is_store && sq_full)   st = ST_SQ_FULL;
    else if (grp_hold)                   st = ST_GRP_STALL;
    else                                 st = ST_OK;
  end
  assign disp_status = st;
  assign accept      = disp_valid && (st == ST_OK);

  // Lowest free slot takes the dispatch.
  always_comb begin
    wr_sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        wr_sel    = '0;
        wr_sel[i] = accept;
      end
    end
  end

  // Same-cycle broadcasts are folded into the incoming operation.
  assign in_rdy   = disp_src_rdy | {wake_valid && wake_tag == disp_src1,
                                    wake_valid && wake_tag == disp_src0};
  assign in_known = disp_lat_known | in_rdy | {lat_valid && lat_tag == disp_src1,
                                               lat_valid && lat_tag == disp_src0};
  assign in_mem   = disp_mem_dep && !(mem_clr_valid && mem_clr_tag == disp_tag);
  assign in_cls   = entry_class(in_rdy, in_known, in_mem);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    iqt_slot #(.TAG_W(TAG_W), .NRES(NRES), .USR_W(USR_W), .AGE_W(AGE_W)) u_slot (
      .clk(clk), .rst(rst), .wr_en(wr_sel[g]), .wr_tag(disp_tag),
      .wr_src0(disp_src0), .wr_src1(disp_src1), .wr_rdy(in_rdy), .wr_known(in_known),
      .wr_mem(in_mem), .wr_cls(in_cls), .wr_res(disp_res), .wr_users(disp_users),
      .wr_urgent(disp_urgent), .wr_age(age_ctr),
      .wake_valid(wake_valid), .wake_tag(wake_tag), .lat_valid(lat_valid),
      .lat_tag(lat_tag), .mem_clr_valid(mem_clr_valid), .mem_clr_tag(mem_clr_tag),
      .issue_go(go[g]), .wb_valid(wb_valid), .wb_tag(wb_tag),
      .o_valid(occ[g]), .o_cls(cls_v[g]), .o_tag(slot_tag[g]), .o_age(slot_age[g]),
      .o_users(slot_usr[g]), .o_res(slot_res[g]), .o_urgent(urg_v[g]),
      .o_to_pend(to_pend_vec[g]), .o_to_rdy(to_rdy_vec[g])
    );
    assign rank[g] = $signed({2'b00, slot_age[g]}) -
                     $signed({{(RANK_W - USR_W){1'b0}}, slot_usr[g]});
    assign cand[g] = occ[g] && cls_v[g] == CL_RDY && ((slot_res[g] & ~res_free) == '0);
    assign go[g]   = sel_v && (sel_idx == IDX_W'(g));
    assign wait_vec[g] = occ[g] && cls_v[g] == CL_WAIT;
    assign pend_vec[g] = occ[g] && cls_v[g] == CL_PEND;
    assign rdy_vec[g]  = occ[g] && cls_v[g] == CL_RDY;
    assign iss_vec[g]  = occ[g] && cls_v[g] == CL_ISS;
  end

  iqt_select #(.DEPTH(DEPTH), .AGE_W(AGE_W), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_sel (
    .cand(cand), .urgent(urg_v), .rank(rank), .age(slot_age),
    .found(sel_v), .pick(sel_idx)
  );

  always_comb begin
    busy_n = '0;
    for (int i = 0; i < DEPTH; i++)
      if (occ[i] && cls_v[i] == CL_RDY) busy_n = busy_n | (slot_res[i] & ~res_free);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      age_ctr     <= '0;
      issue_valid <= 1'b0;
      issue_tag   <= '0;
      busy_res    <= '0;
      token_stall <= 1'b0;
    end else begin
      if (accept) age_ctr <= age_ctr + 1'b1;
      issue_valid <= sel_v;
      issue_tag   <= slot_tag[sel_idx];
      busy_res    <= busy_n;
      token_stall <= disp_valid &&
                     (st == ST_WIN_FULL || st == ST_LQ_FULL || st == ST_SQ_FULL);
    end
  end
endmodule

// File: rtl/iqt_window_chk.sv
module iqt_window_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4,
  parameter int NRES  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             disp_valid,
  input logic [TAG_W-1:0] disp_tag,
  input logic [2:0]       disp_status,
  input logic             token_stall,
  input logic [NRES-1:0]  res_free,
  input logic [NRES-1:0]  busy_res,
  input logic             issue_valid,
  input logic             wb_valid,
  input logic [DEPTH-1:0] wait_vec,
  input logic [DEPTH-1:0] pend_vec,
  input logic [DEPTH-1:0] rdy_vec,
  input logic [DEPTH-1:0] iss_vec,
  input logic [DEPTH-1:0] to_pend_vec,
  input logic [DEPTH-1:0] to_rdy_vec,
  input logic [TAG_W-1:0] slot_tag [DEPTH]
);
  logic [DEPTH-1:0] occ;
  assign occ = wait_vec | pend_vec | rdy_vec | iss_vec;

  // R5: a refused dispatch never adds a slot
  a_r5_refused_no_growth: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_status != 3'd0) |=> ($countones(occ) <= $past($countones(occ))));

  // R2: an accepted dispatch never loses occupancy
  a_r2_accept_holds_count: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_status == 3'd0) |=> ($countones(occ) >= $past($countones(occ))));

  // R7: issued class grows only with a reported issue, by at most one
  a_r7_issue_reported: assert property (@(posedge clk) disable iff (rst)
    ($countones(iss_vec) > $past($countones(iss_vec))) |-> issue_valid);
  a_r7_single_issue: assert property (@(posedge clk) disable iff (rst)
    $countones(iss_vec) <= $past($countones(iss_vec)) + 1);

  // R10: issued class shrinks only after a write-back
  a_r10_retire_needs_wb: assert property (@(posedge clk) disable iff (rst)
    ($countones(iss_vec) < $past($countones(iss_vec))) |-> $past(wb_valid));

  // R4: promotions start from a lower class
  a_r4_pend_from_wait: assert property (@(posedge clk) disable iff (rst)
    (to_pend_vec & ~$past(wait_vec)) == '0);
  a_r4_rdy_from_lower: assert property (@(posedge clk) disable iff (rst)
    (to_rdy_vec & ~($past(wait_vec) | $past(pend_vec))) == '0);

  // R9: busy bits only name resources that were not free
  a_r9_busy_not_free: assert property (@(posedge clk) disable iff (rst)
    (busy_res & $past(res_free)) == '0);

  // R6: token stall only follows a request
  a_r6_stall_after_request: assert property (@(posedge clk) disable iff (rst)
    token_stall |-> $past(disp_valid));

  // R11: no accepted dispatch may reuse a live tag
  for (genvar g = 0; g < DEPTH; g++) begin : g_dup
    a_r11_unique_tag: assert property (@(posedge clk) disable iff (rst)
      (disp_valid && disp_status == 3'd0 && occ[g]) |-> (slot_tag[g] != disp_tag));
  end
endmodule

bind iqt_window iqt_window_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NRES(NRES)) u_chk (
  .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_tag(disp_tag),
  .disp_status(disp_status), .token_stall(token_stall), .res_free(res_free),
  .busy_res(busy_res), .issue_valid(issue_valid), .wb_valid(wb_valid),
  .wait_vec(wait_vec), .pend_vec(pend_vec), .rdy_vec(rdy_vec), .iss_vec(iss_vec),
  .to_pend_vec(to_pend_vec), .to_rdy_vec(to_rdy_vec), .slot_tag(slot_tag)
);

// File: tb/iqt_window_test.sv
`timescale 1ns/1ps
module iqt_window_test;
  localparam int DEPTH = 8, TAG_W = 4, NRES = 4, USR_W = 3, AGE_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic disp_valid, disp_mem_dep, disp_urgent, disp_is_load, disp_is_store;
  logic lq_full, sq_full, grp_hold, wake_valid, lat_valid, mem_clr_valid, wb_valid;
  logic [TAG_W-1:0] disp_tag, disp_src0, disp_src1, wake_tag, lat_tag, mem_clr_tag, wb_tag;
  logic [1:0] disp_src_rdy, disp_lat_known;
  logic [NRES-1:0] disp_res, res_free, busy_res;
  logic [USR_W-1:0] disp_users;
  logic [2:0] disp_status;
  logic token_stall, issue_valid;
  logic [TAG_W-1:0] issue_tag;
  logic [DEPTH-1:0] wait_vec, pend_vec, rdy_vec, iss_vec, to_pend_vec, to_rdy_vec;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iqt_window #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NRES(NRES), .USR_W(USR_W), .AGE_W(AGE_W)) uut (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_src0(disp_src0), .disp_src1(disp_src1), .disp_src_rdy(disp_src_rdy),
    .disp_lat_known(disp_lat_known), .disp_mem_dep(disp_mem_dep), .disp_res(disp_res),
    .disp_users(disp_users), .disp_urgent(disp_urgent), .disp_is_load(disp_is_load),
    .disp_is_store(disp_is_store), .lq_full(lq_full), .sq_full(sq_full),
    .grp_hold(grp_hold), .disp_status(disp_status), .token_stall(token_stall),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .lat_valid(lat_valid), .lat_tag(lat_tag),
    .mem_clr_valid(mem_clr_valid), .mem_clr_tag(mem_clr_tag), .res_free(res_free),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .issue_valid(issue_valid), .issue_tag(issue_tag),
    .busy_res(busy_res), .wait_vec(wait_vec), .pend_vec(pend_vec), .rdy_vec(rdy_vec),
    .iss_vec(iss_vec), .to_pend_vec(to_pend_vec), .to_rdy_vec(to_rdy_vec)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle;
    disp_valid = 0; disp_tag = '0; disp_src0 = '0; disp_src1 = '0; disp_src_rdy = '0;
    disp_lat_known = '0; disp_mem_dep = 0; disp_res = '0; disp_users = '0;
    disp_urgent = 0; disp_is_load = 0; disp_is_store = 0; lq_full = 0; sq_full = 0;
    grp_hold = 0; wake_valid = 0; wake_tag = '0; lat_valid = 0; lat_tag = '0;
    mem_clr_valid = 0; mem_clr_tag = '0; wb_valid = 0; wb_tag = '0;
  endtask

  task automatic do_reset;
    idle();
    res_free = '0;
    rst = 1;
    tick();
    tick();
    rst = 0;
  endtask

  task automatic disp(input int tag, input int s0, input int s1, input logic [1:0] rdy,
                      input logic [1:0] known, input logic mem, input logic [NRES-1:0] res,
                      input int users, input logic urg);
    disp_valid = 1; disp_tag = TAG_W'(tag); disp_src0 = TAG_W'(s0); disp_src1 = TAG_W'(s1);
    disp_src_rdy = rdy; disp_lat_known = known; disp_mem_dep = mem; disp_res = res;
    disp_users = USR_W'(users); disp_urgent = urg;
    tick();
    disp_valid = 0;
  endtask

  function automatic int occ_cnt();
    return $countones(wait_vec | pend_vec | rdy_vec | iss_vec);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "occupancy", occ_cnt(), 0);
    chk("R1", "issue_valid", issue_valid, 0);
    chk("R1", "busy_res", busy_res, 0);
    chk("R1", "token_stall", token_stall, 0);
    chk("R1", "events", {to_pend_vec, to_rdy_vec}, 0);

    // R2 dispatch classification (resources withheld so nothing issues)
    disp(1, 0, 0, 2'b11, 2'b00, 0, 4'b0001, 0, 0);
    chk("R2", "ready at dispatch", rdy_vec, 8'b0000_0001);
    disp(2, 8, 9, 2'b01, 2'b00, 0, 4'b0010, 0, 0);
    chk("R2", "waiting at dispatch", wait_vec, 8'b0000_0010);
    disp(3, 7, 14, 2'b01, 2'b10, 0, 4'b0001, 0, 0);
    chk("R2", "pending at dispatch", pend_vec, 8'b0000_0100);
    disp(4, 0, 0, 2'b11, 2'b00, 1, 4'b0001, 5, 0);
    chk("R2", "mem dep pending", pend_vec, 8'b0000_1100);

    // R3 latency broadcast, then wakeup, then memory clear
    lat_valid = 1; lat_tag = 4'd9; tick(); lat_valid = 0;
    chk("R3", "pend after latency", pend_vec, 8'b0000_1110);
    chk("R4", "to_pend event", to_pend_vec, 8'b0000_0010);
    chk("R4", "no to_rdy", to_rdy_vec, 8'b0);
    wake_valid = 1; wake_tag = 4'd9; tick(); wake_valid = 0;
    chk("R3", "ready after wakeup", rdy_vec, 8'b0000_0011);
    chk("R4", "to_rdy event", to_rdy_vec, 8'b0000_0010);
    mem_clr_valid = 1; mem_clr_tag = 4'd4; tick(); mem_clr_valid = 0;
    chk("R3", "ready after mem clear", rdy_vec, 8'b0000_1011);
    chk("R3", "pending left", pend_vec, 8'b0000_0100);
    wake_valid = 1; wake_tag = 4'd11;
    disp(5, 10, 11, 2'b01, 2'b00, 0, 4'b0100, 0, 0);
    wake_valid = 0;
    chk("R2", "same-cycle wakeup at dispatch", rdy_vec, 8'b0001_1011);

    // R4 waiting straight to ready
    disp(6, 12, 13, 2'b00, 2'b00, 0, 4'b0001, 7, 0);
    chk("R2", "waiting two unknown", wait_vec, 8'b0010_0000);
    wake_valid = 1; wake_tag = 4'd12; tick();
    chk("R4", "half woken stays waiting", wait_vec, 8'b0010_0000);
    wake_tag = 4'd13; tick(); wake_valid = 0;
    chk("R4", "chain ready", rdy_vec, 8'b0011_1011);
    chk("R4", "chain to_pend", to_pend_vec, 8'b0010_0000);
    chk("R4", "chain to_rdy", to_rdy_vec, 8'b0010_0000);

    // R9 busy mask with nothing free: tags 1,2,4,5,6 ready
    tick();
    chk("R9", "busy all withheld", busy_res, 4'b0111);
    chk("R7", "no issue without resources", issue_valid, 0);

    // R7 resource-gated selection then rank order
    res_free = 4'b1110; tick();
    chk("R7", "issue valid", issue_valid, 1);
    chk("R7", "only free candidate wins", issue_tag, 2);
    chk("R9", "busy resource 0", busy_res, 4'b0001);
    res_free = 4'b1111;
    tick(); chk("R7", "lowest rank", issue_tag, 4);
    tick(); chk("R7", "rank tie older first", issue_tag, 6);
    tick(); chk("R7", "rank zero", issue_tag, 1);
    tick(); chk("R7", "last ready", issue_tag, 5);
    chk("R9", "busy clears", busy_res, 0);
    tick(); chk("R7", "pending never issues", issue_valid, 0);
    chk("R7", "issued class", iss_vec, 8'b0011_1011);

    // R10 write-back retires only issued slots
    res_free = '0;
    wb_valid = 1; wb_tag = 4'd2; tick();
    chk("R10", "issued slot freed", iss_vec, 8'b0011_1001);
    wb_tag = 4'd3; tick(); wb_valid = 0;
    chk("R10", "pending slot untouched", pend_vec, 8'b0000_0100);
    disp(7, 0, 0, 2'b11, 2'b00, 0, 4'b1000, 0, 0);
    chk("R10", "freed slot reused", rdy_vec, 8'b0000_0010);

    // R8 urgent beats a better rank
    do_reset();
    disp(1, 0, 0, 2'b11, 2'b00, 0, 4'b0001, 7, 0);
    disp(2, 0, 0, 2'b11, 2'b00, 0, 4'b0001, 0, 1);
    res_free = 4'b1111;
    tick(); chk("R8", "urgent first", issue_tag, 2);
    tick(); chk("R8", "then the rest", issue_tag, 1);

    // R5 / R6 full window and status sweep
    do_reset();
    for (int t = 0; t < DEPTH; t++) disp(t, 0, 0, 2'b11, 2'b00, 0, 4'b0001, 0, 0);
    chk("R5", "window full count", occ_cnt(), DEPTH);
    disp_valid = 1; disp_tag = 4'd9; disp_is_load = 1; lq_full = 1; #1;
    chk("R5", "full beats load queue", disp_status, 3);
    tick();
    chk("R5", "refused no change", occ_cnt(), DEPTH);
    chk("R6", "stall after full", token_stall, 1);
    idle(); tick();
    chk("R6", "stall drops", token_stall, 0);
    res_free = 4'b0001; tick(); res_free = '0;
    chk("R7", "oldest of equals", issue_tag, 0);
    wb_valid = 1; wb_tag = 4'd0; tick(); wb_valid = 0;
    chk("R10", "one slot free", occ_cnt(), DEPTH - 1);
    for (int c = 0; c < 32; c++) begin
      int e;
      disp_is_load = c[0]; disp_is_store = c[1]; lq_full = c[2]; sq_full = c[3];
      grp_hold = c[4];
      e = (c[0] && c[2]) ? 1 : (c[1] && c[3]) ? 2 : c[4] ? 4 : 0;
      #1;
      chk("R5", $sformatf("status code combo %0d", c), disp_status, e);
    end
    idle();
    disp_valid = 1; disp_tag = 4'd9; grp_hold = 1; tick();
    chk("R6", "group stall no token", token_stall, 0);
    chk("R5", "group refused", occ_cnt(), DEPTH - 1);
    grp_hold = 0; disp_is_load = 1; lq_full = 1; tick();
    chk("R6", "load queue stall", token_stall, 1);
    chk("R5", "load refused", occ_cnt(), DEPTH - 1);
    idle();
    disp(8, 0, 0, 2'b11, 2'b00, 0, 4'b0001, 0, 0);
    chk("R10", "refill occupancy", occ_cnt(), DEPTH);
    chk("R2", "lowest free slot", rdy_vec[0], 1);
    chk("R6", "accepted no token", token_stall, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule